// File: doc/BRIEF.md
# Interrupt pending latch controller

This block keeps the pending and active state for a parameterized set of peripheral interrupt lines (up to 240). Every line is configured as either a level source or a pulse source. Request inputs are registered on the rising clock edge; a pulse line pends on a low-to-high transition of its registered value, while a level line pends whenever its registered value is high and the interrupt is not active. The core reports handler entry and handler return through two strobes that carry an interrupt number. Entry clears pending and marks the interrupt active. Return clears active and, for a level line that is still high, pends the interrupt again.

Software can also pend an interrupt by writing its number to a trigger register through a simple write port. A privileged write to the trigger register always takes effect. An unprivileged write takes effect only while an access-enable control bit is set, and only a privileged write may change that bit. Out-of-range numbers are dropped.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Request inputs are registered once; a line's request pends its interrupt on the second rising edge after the input is driven, and a one-cycle pulse is held pending after the input falls.
- R2: An entry strobe with number k (k below NUM_IRQ) clears pending[k] and sets active[k] on the next edge; active[k] never rises without such a strobe.
- R3: A return strobe with number k clears active[k] on the next edge; if line k is a level line whose registered input is high, pending[k] is set on that same edge.
- R4: While active[k] is set, a level line k that stays high does not set pending[k].
- R5: While active[k] is set, a new low-to-high transition on pulse line k sets pending[k] again.
- R6: A write with wr_sel = 0 (trigger register) sets pending for the number in wr_data[8:0]; wr_data[31:9] has no effect on the result.
- R7: A trigger number at or above NUM_IRQ, or above 239, changes no pending or active bit.
- R8: A privileged trigger write always takes effect; an unprivileged trigger write takes effect only while unpriv_trig_en is 1.
- R9: The access-enable bit is bit 0 of the control register (wr_sel = 1); it is written only by a privileged write and an unprivileged write leaves it unchanged.
- R10: A synchronous active-low reset clears all pending, active and access-enable state.
- R11: A pulse line held high sets pending only once; after entry clears it, it stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_IRQ | Peripheral request lines |
| irq_is_pulse | input | NUM_IRQ | Per-line mode: 1 pulse, 0 level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 trigger, 1 control |
| wr_priv | input | 1 | Write is privileged |
| wr_data | input | 32 | Write data |
| entry_vld | input | 1 | Handler entry strobe |
| entry_id | input | 9 | Interrupt number being entered |
| exit_vld | input | 1 | Handler return strobe |
| exit_id | input | 9 | Interrupt number returning |
| pending | output | NUM_IRQ | Pending state per interrupt |
| active | output | NUM_IRQ | Active state per interrupt |
| unpriv_trig_en | output | 1 | Unprivileged trigger access enabled |

## Verification
The hardest situations to reach are the ones where a request line changes while its interrupt is active: a level line held high across the whole handler and still high at return, and a pulse line that falls and rises again between entry and return. The bench drives these as scripted sequences on one level line and one pulse line, checking the pending and active vectors after every entry and return strobe. The trigger register is swept over all 512 values of the number field with varied upper bits so that both range limits and the ignored bits are covered, and every line is pulsed once in turn.

// File: rtl/irq_pend_pkg.sv
// Package: shared constants and types for the interrupt pending latch controller.
// Assumes interrupt numbers fit in a 9-bit field and at most 240 lines exist.
package irq_pend_pkg;

    localparam int ID_W    = 9;
    localparam int MAX_IRQ = 240;
    localparam int DATA_W  = 32;

    // Register select of the write port
    typedef enum logic {
        SEL_TRIG = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // Smallest number that is out of range for a given line count
    function automatic int id_limit(input int num_irq);
        return (num_irq < MAX_IRQ) ? num_irq : MAX_IRQ;
    endfunction

endpackage

// File: rtl/irq_input_sync.sv
// Module: registers each request line once and turns it into a per-line set
// request. Level lines request while their registered value is high; pulse
// lines request for one cycle on a low-to-high change of the registered value.
// Assumes irq_is_pulse is static configuration.
module irq_input_sync #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] irq_is_pulse,
    output logic [NUM_IRQ-1:0] lvl_hi,
    output logic [NUM_IRQ-1:0] pls_edge
);

    logic [NUM_IRQ-1:0] samp_q;
    logic [NUM_IRQ-1:0] prev_q;

    // Capture the request lines and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            prev_q <= '0;
        end else begin
            samp_q <= irq_in;
            prev_q <= samp_q;
        end
    end

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
        // Split each registered line into a level request or an edge request
        always_comb begin
            if (irq_is_pulse[gi]) begin
                lvl_hi[gi]   = 1'b0;
                pls_edge[gi] = samp_q[gi] & ~prev_q[gi];
            end else begin
                lvl_hi[gi]   = samp_q[gi];
                pls_edge[gi] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_sw_trigger.sv
// Module: decodes the register write port. Holds the unprivileged access
// enable (control register bit 0) and turns an accepted trigger write into a
// one-hot set vector. Assumes writes are single-cycle strobes.
module irq_sw_trigger
    import irq_pend_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic               wr_priv,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_IRQ-1:0] sw_set,
    output logic               unpriv_en
);

    localparam int              LIMIT    = id_limit(NUM_IRQ);
    localparam logic [ID_W-1:0] LIMIT_ID = ID_W'(LIMIT);

    logic [ID_W-1:0] trig_id;
    logic            trig_ok;
    logic            ctrl_wr;
    logic            unused_hi;

    assign trig_id   = wr_data[ID_W-1:0];
    assign unused_hi = ^wr_data[DATA_W-1:ID_W];

    // Accept a trigger write when privileged or enabled, and the number is in range
    always_comb begin
        trig_ok = wr_en && (reg_sel_e'(wr_sel) == SEL_TRIG)
                  && (wr_priv || unpriv_en) && (trig_id < LIMIT_ID);
        ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL) && wr_priv;
    end

    // Hold the access-enable bit; only privileged control writes change it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unpriv_en <= 1'b0;
        end else if (ctrl_wr) begin
            unpriv_en <= wr_data[0];
        end
    end

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_dec
        // One comparator per line turns the accepted number into a set bit
        assign sw_set[gi] = trig_ok && (trig_id == ID_W'(gi));
    end

endmodule

// File: rtl/irq_line_state.sv
// Module: per-interrupt pending and active flops. Entry clears pending and
// sets active; return clears active. Level requests are masked while active
// and while being entered; pulse and software requests win over entry clear.
// Assumes at most one entry and one return strobe per cycle.
module irq_line_state
    import irq_pend_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] lvl_hi,
    input  logic [NUM_IRQ-1:0] pls_edge,
    input  logic [NUM_IRQ-1:0] sw_set,
    input  logic               entry_vld,
    input  logic [ID_W-1:0]    entry_id,
    input  logic               exit_vld,
    input  logic [ID_W-1:0]    exit_id,
    output logic [NUM_IRQ-1:0] pending,
    output logic [NUM_IRQ-1:0] active
);

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_st
        logic ent_hit;
        logic ret_hit;
        logic lvl_set;
        logic pend_nxt;
        logic act_nxt;

        // Decode strobes for this line and form next-state values
        always_comb begin
            ent_hit  = entry_vld && (entry_id == ID_W'(gi));
            ret_hit  = exit_vld && (exit_id == ID_W'(gi));
            lvl_set  = lvl_hi[gi] && (!active[gi] || ret_hit) && !ent_hit;
            pend_nxt = (pending[gi] && !ent_hit) || lvl_set
                       || pls_edge[gi] || sw_set[gi];
            act_nxt  = ent_hit || (active[gi] && !ret_hit);
        end

        // Store pending and active for this line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[gi] <= 1'b0;
                active[gi]  <= 1'b0;
            end else begin
                pending[gi] <= pend_nxt;
                active[gi]  <= act_nxt;
            end
        end
    end

endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: top of the interrupt pending latch controller. Connects the input
// sampling stage, the software trigger decoder and the per-line state.
// Assumes the core issues entry/return strobes with valid numbers it tracks.
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] irq_is_pulse,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic               wr_priv,
    input  logic [31:0]        wr_data,
    input  logic               entry_vld,
    input  logic [8:0]         entry_id,
    input  logic               exit_vld,
    input  logic [8:0]         exit_id,
    output logic [NUM_IRQ-1:0] pending,
    output logic [NUM_IRQ-1:0] active,
    output logic               unpriv_trig_en
);

    logic [NUM_IRQ-1:0] lvl_hi;
    logic [NUM_IRQ-1:0] pls_edge;
    logic [NUM_IRQ-1:0] sw_set;

    irq_input_sync #(.NUM_IRQ(NUM_IRQ)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .irq_is_pulse(irq_is_pulse),
        .lvl_hi      (lvl_hi),
        .pls_edge    (pls_edge)
    );

    irq_sw_trigger #(.NUM_IRQ(NUM_IRQ)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_priv  (wr_priv),
        .wr_data  (wr_data),
        .sw_set   (sw_set),
        .unpriv_en(unpriv_trig_en)
    );

    irq_line_state #(.NUM_IRQ(NUM_IRQ)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_hi   (lvl_hi),
        .pls_edge (pls_edge),
        .sw_set   (sw_set),
        .entry_vld(entry_vld),
        .entry_id (entry_id),
        .exit_vld (exit_vld),
        .exit_id  (exit_id),
        .pending  (pending),
        .active   (active)
    );

endmodule

// File: rtl/irq_pend_chk.sv
// Checker: temporal properties of the pending latch controller, bound to the top.
module irq_pend_chk #(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_is_pulse,
    input logic               wr_en,
    input logic               wr_priv,
    input logic               entry_vld,
    input logic [8:0]         entry_id,
    input logic               exit_vld,
    input logic [8:0]         exit_id,
    input logic [NUM_IRQ-1:0] pending,
    input logic [NUM_IRQ-1:0] active,
    input logic               unpriv_trig_en
);

    // R10: reset clears every state bit
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (pending == '0 && active == '0 && !unpriv_trig_en));

    // R9: an unprivileged write leaves the access-enable bit unchanged
    p_ctrl_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> $stable(unpriv_trig_en));

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_chk
        // R2: active only rises after an entry strobe for that line
        p_active_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(active[gi]) |-> $past(entry_vld && entry_id == 9'(gi)));

        // R2: entry of a level line with no write clears pending, sets active
        p_entry_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (entry_vld && entry_id == 9'(gi) && !irq_is_pulse[gi] && !wr_en)
            |=> (!pending[gi] && active[gi]));

        // R3: return without a same-line entry clears active
        p_exit_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (exit_vld && exit_id == 9'(gi) && !(entry_vld && entry_id == 9'(gi)))
            |=> !active[gi]);
    end

endmodule

bind irq_pend_ctrl irq_pend_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_is_pulse  (irq_is_pulse),
    .wr_en         (wr_en),
    .wr_priv       (wr_priv),
    .entry_vld     (entry_vld),
    .entry_id      (entry_id),
    .exit_vld      (exit_vld),
    .exit_id       (exit_id),
    .pending       (pending),
    .active        (active),
    .unpriv_trig_en(unpriv_trig_en)
);

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;

    localparam int N = 240;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_in;
    logic [N-1:0] irq_is_pulse;
    logic         wr_en, wr_sel, wr_priv;
    logic [31:0]  wr_data;
    logic         entry_vld, exit_vld;
    logic [8:0]   entry_id, exit_id;
    logic [N-1:0] pending, active;
    logic         unpriv_trig_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_pend_ctrl #(.NUM_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_is_pulse(irq_is_pulse),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_priv(wr_priv), .wr_data(wr_data),
        .entry_vld(entry_vld), .entry_id(entry_id),
        .exit_vld(exit_vld), .exit_id(exit_id),
        .pending(pending), .active(active), .unpriv_trig_en(unpriv_trig_en)
    );

    function automatic logic [N-1:0] oh(input int k);
        logic [N-1:0] v = '0;
        if (k >= 0 && k < N) v[k] = 1'b1;
        return v;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic priv, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_priv = priv; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_entry(input int k);
        entry_vld = 1'b1; entry_id = 9'(k);
        step(1);
        entry_vld = 1'b0;
    endtask

    task automatic do_exit(input int k);
        exit_vld = 1'b1; exit_id = 9'(k);
        step(1);
        exit_vld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_priv = 1'b0;
        wr_data = '0; entry_vld = 1'b0; exit_vld = 1'b0; entry_id = '0; exit_id = '0;
        for (int i = 0; i < N; i++) irq_is_pulse[i] = i[0];
        step(3);
        chk_vec("R10 reset pending", pending, '0);
        chk_vec("R10 reset active", active, '0);
        chk_bit("R10 reset enable", unpriv_trig_en, 1'b0);
        rst_n = 1'b1;
        step(1);

        // R6 R7: sweep every number field value with varied upper bits
        for (int id = 0; id < 512; id++) begin
            do_write(1'b0, 1'b1, ((32'(id) * 32'd40503) << 9) | 32'(id));
            chk_vec("R6/R7 trigger sweep pending", pending, oh(id));
            chk_vec("R7 trigger sweep active", active, '0);
            if (id < N) begin
                do_entry(id);
                chk_vec("R2 entry after trigger", active, oh(id));
                do_exit(id);
                chk_vec("R3 exit clears", pending | active, '0);
            end
        end

        // R8 R9: privilege gating
        do_write(1'b0, 1'b0, 32'd5);
        chk_vec("R8 unpriv dropped while disabled", pending, '0);
        do_write(1'b1, 1'b0, 32'd1);
        chk_bit("R9 unpriv control write ignored", unpriv_trig_en, 1'b0);
        do_write(1'b1, 1'b1, 32'd1);
        chk_bit("R9 priv control write sets", unpriv_trig_en, 1'b1);
        do_write(1'b0, 1'b0, 32'd5);
        chk_vec("R8 unpriv accepted while enabled", pending, oh(5));
        do_write(1'b1, 1'b0, 32'd0);
        chk_bit("R9 unpriv clear ignored", unpriv_trig_en, 1'b1);
        do_write(1'b0, 1'b0, 32'd300);
        chk_vec("R7 unpriv out of range", pending, oh(5));
        do_entry(5); do_exit(5);
        do_write(1'b1, 1'b1, 32'd0);
        chk_bit("R9 priv control write clears", unpriv_trig_en, 1'b0);
        do_write(1'b0, 1'b1, 32'd6);
        chk_vec("R8 priv always accepted", pending, oh(6));
        do_entry(6); do_exit(6);

        // R1: one-cycle pulse on every line in turn
        for (int i = 0; i < N; i++) begin
            irq_in[i] = 1'b1;
            step(1);
            irq_in[i] = 1'b0;
            chk_vec("R1 not yet pending", pending, '0);
            step(1);
            chk_vec("R1 latched after two edges", pending, oh(i));
            step(2);
            chk_vec("R1 held after input falls", pending, oh(i));
            do_entry(i); do_exit(i);
            chk_vec("R1 cleared by service", pending | active, '0);
        end

        // R5 R11: pulse line 1
        irq_in[1] = 1'b1;
        step(2);
        chk_vec("R1 pulse pends", pending, oh(1));
        do_entry(1);
        chk_vec("R2 pulse entry pending", pending, '0);
        chk_vec("R2 pulse entry active", active, oh(1));
        step(3);
        chk_vec("R11 held pulse no re-pend", pending, '0);
        irq_in[1] = 1'b0;
        step(2);
        irq_in[1] = 1'b1;
        step(2);
        chk_vec("R5 new pulse while active", pending, oh(1));
        do_exit(1);
        chk_vec("R3 pulse exit active", active, '0);
        chk_vec("R5 pending kept after exit", pending, oh(1));
        irq_in[1] = 1'b0;
        do_entry(1); do_exit(1);
        chk_vec("R11 pulse clean", pending | active, '0);

        // R3 R4: level line 2
        irq_in[2] = 1'b1;
        step(2);
        chk_vec("R1 level pends", pending, oh(2));
        do_entry(2);
        chk_vec("R2 level entry pending", pending, '0);
        chk_vec("R2 level entry active", active, oh(2));
        step(4);
        chk_vec("R4 no re-pend while active", pending, '0);
        do_exit(2);
        chk_vec("R3 level re-pends at return", pending, oh(2));
        chk_vec("R3 level active cleared", active, '0);
        irq_in[2] = 1'b0;
        step(2);
        do_entry(2); do_exit(2);
        chk_vec("R3 low level no re-pend", pending | active, '0);

        // R10: reset mid-run
        do_write(1'b1, 1'b1, 32'd1);
        do_write(1'b0, 1'b1, 32'd9);
        do_write(1'b0, 1'b1, 32'd10);
        do_entry(10);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        chk_vec("R10 reset clears pending", pending, '0);
        chk_vec("R10 reset clears active", active, '0);
        chk_bit("R10 reset clears enable", unpriv_trig_en, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule